// File: doc/BRIEF.md
# Command Queue Packet Launcher

This block keeps a small queue of 32-bit command words that a host fills through a simple write port. When the host raises the start bit, the block turns the queue into one low-power command packet and sends it out one byte per cycle. A packet is always a three-byte header: the data identifier, then two bytes. It may be followed by payload bytes. If the command asks for it, a bus-turnaround request is raised after the packet. The block shows a busy flag while it sends and a sticky command-done flag when it finishes. Checksums and the physical lanes are handled downstream.

The first queue word describes the packet. Its low byte is a configuration code, its next byte is the data identifier, and its upper half holds either two parameter bytes (short packet) or a byte count (long packet). Long-packet payload is packed into the following queue words, least significant byte first. The host must keep the engine in command mode. A start request in any other mode is refused.

Top module: `cmdq_launcher`

## Requirements
- R1: After reset, busy, cmd_done, tx_valid, tx_first, tx_last and bta_req are all low.
- R2: Queue word 0 is laid out as follows: bits 7:0 are the config byte, bits 15:8 are the data identifier, and bits 31:16 are two further bytes. The header goes out as bits 15:8, then bits 23:16, then bits 31:24.
- R3: When config bit 1 is 0, the packet is short. Exactly the three header bytes are sent, and tx_last marks the third.
- R4: When config bit 1 is 1, the packet is long. Bits 31:16 of word 0 give the payload byte count. Payload byte k follows the header and comes from queue word 1+k/4, bits 8*(k%4)+7 down to 8*(k%4).
- R5: The long-packet payload is clipped to (Q−1)*4 bytes. Q is the queue-size register, and a value above the queue depth counts as the depth.
- R6: A launch happens only when a start-register write takes the start bit from 0 to 1. Writing 1 when it is already 1 starts nothing.
- R7: While busy, a write to the start register is ignored. The stored start bit keeps its value.
- R8: A start request is refused, and no byte is sent, when the mode register is not 0 (command mode) or when the queue size is 0.
- R9: busy is high from the cycle after the start write. The first header byte is valid four cycles after the start write.
- R10: cmd_done rises in the cycle after the last byte (no turnaround), in the same cycle that busy falls. It stays high until a write to the clear address or the next launch.
- R11: When config bit 2 is 1, bta_req pulses for exactly one cycle right after the last byte. busy stays high and cmd_done stays low until rd_ready is seen. cmd_done then rises one cycle later.
- R12: Packet bytes appear on tx_valid in back-to-back cycles. tx_first is high on the first byte only.

Write address map (ADDR_W = log2(DEPTH)+1 bits):
- Top address bit set: the low bits select a queue word.
- Top address bit clear, low two bits:
  - 0 is the start register (bit 0).
  - 1 is the mode register (bits 1:0).
  - 2 is the queue size (bits 5:0).
  - 3 is the done-clear address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Write address |
| cfg_wdata | input | 32 | Write data |
| rd_ready | input | 1 | Read-response block has data ready |
| tx_valid | output | 1 | A packet byte is present |
| tx_byte | output | 8 | Packet byte |
| tx_first | output | 1 | First byte of the packet |
| tx_last | output | 1 | Last byte of the packet |
| bta_req | output | 1 | One-cycle bus-turnaround request |
| busy | output | 1 | Packet in progress |
| cmd_done | output | 1 | Sticky completion flag |

## Verification
Call the clock edge that samples the start write cycle 0. Then busy is due in cycle 1 and the first header byte in cycle 4. Every later byte follows one cycle after the previous one. cmd_done, or bta_req for a turnaround command, is due in the cycle after the last byte. The bench samples on the falling edge and counts cycles from the start-write edge. It compares the observed first-byte cycle and end cycle with these exact numbers, not just waiting for the events. For a turnaround command it holds rd_ready low for several cycles and confirms that completion waits. It then confirms that cmd_done appears exactly one cycle after rd_ready is sampled.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int WORD_W   = 32;
  localparam int QSZ_W    = 6;
  localparam int BYTE_W   = 8;
  localparam int LEN_W    = 16;

  // control addresses (top address bit clear)
  localparam logic [1:0] CTL_START = 2'd0;
  localparam logic [1:0] CTL_MODE  = 2'd1;
  localparam logic [1:0] CTL_QSIZE = 2'd2;
  localparam logic [1:0] CTL_CLEAR = 2'd3;

  localparam logic [1:0] MODE_CMD  = 2'd0;

  // config byte bit positions
  localparam int CFG_LONG_BIT = 1;
  localparam int CFG_TA_BIT   = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH0, ST_FETCH1, ST_HDR, ST_PAY, ST_FIN, ST_WAIT
  } cq_state_e;
endpackage

// File: rtl/cmdq_mem.sv
module cmdq_mem #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int QA_W = $clog2(DEPTH),
  localparam int ADDR_W = QA_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [WORD_W-1:0]  cfg_wdata,
  input  logic               busy_i,
  output logic               q_we,
  output logic [QA_W-1:0]    q_waddr,
  output logic [QSZ_W-1:0]   qsize_o,
  output logic               launch_o,
  output logic               done_clr_o
);
  logic             start_q;
  logic [1:0]       mode_q;
  logic [QSZ_W-1:0] qsize_q;
  logic             is_q, ctl_we, gate, start_wr;

  assign is_q       = cfg_addr[ADDR_W-1];
  assign ctl_we     = cfg_we && !is_q;
  assign q_we       = cfg_we && is_q;
  assign q_waddr    = cfg_addr[QA_W-1:0];
  assign gate       = busy_i || launch_o;
  assign start_wr   = ctl_we && (cfg_addr[1:0] == CTL_START) && !gate;
  assign done_clr_o = ctl_we && (cfg_addr[1:0] == CTL_CLEAR);
  assign qsize_o    = qsize_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= 1'b0;
      mode_q   <= MODE_CMD;
      qsize_q  <= '0;
      launch_o <= 1'b0;
    end else begin
      launch_o <= start_wr && cfg_wdata[0] && !start_q &&
                  (mode_q == MODE_CMD) && (qsize_q != '0);
      if (start_wr) start_q <= cfg_wdata[0];
      if (ctl_we && cfg_addr[1:0] == CTL_MODE)  mode_q  <= cfg_wdata[1:0];
      if (ctl_we && cfg_addr[1:0] == CTL_QSIZE) qsize_q <= cfg_wdata[QSZ_W-1:0];
    end
  end

  AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (rst)
    launch_o |-> !busy_i) else $error("launch while busy"); // R7
  AST_LAUNCH_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    launch_o |-> (qsize_q != '0)) else $error("launch with empty queue"); // R8
endmodule

// File: rtl/cmdq_serializer.sv
module cmdq_serializer
  import cmdq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int QA_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [QSZ_W-1:0]  qsize,
  input  logic              done_clr,
  input  logic [WORD_W-1:0] mem_q,
  input  logic              rd_ready,
  output logic [QA_W-1:0]   rd_ptr,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_first,
  output logic              tx_last,
  output logic              bta_req,
  output logic              busy,
  output logic              cmd_done
);
  cq_state_e         st;
  logic [WORD_W-1:0] w0;
  logic [QSZ_W-1:0]  qs_q;
  logic [1:0]        hidx;
  logic [LEN_W-1:0]  pidx, plen, cap, wc;
  logic [LEN_W-1:0]  plen_m1;

  // payload limit from the queue size captured at launch
  always_comb begin
    int eff;
    eff = (int'(qs_q) > DEPTH) ? DEPTH : int'(qs_q);
    cap = LEN_W'((eff - 1) * 4);
    wc  = mem_q[31:16];
  end
  assign plen_m1 = plen - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      w0       <= '0;
      qs_q     <= '0;
      hidx     <= '0;
      pidx     <= '0;
      plen     <= '0;
      rd_ptr   <= '0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
      tx_first <= 1'b0;
      tx_last  <= 1'b0;
      bta_req  <= 1'b0;
      busy     <= 1'b0;
      cmd_done <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      tx_first <= 1'b0;
      tx_last  <= 1'b0;
      bta_req  <= 1'b0;
      if (done_clr) cmd_done <= 1'b0;
      case (st)
        ST_IDLE: if (launch) begin
          st       <= ST_FETCH0;
          rd_ptr   <= '0;
          qs_q     <= qsize;
          busy     <= 1'b1;
          cmd_done <= 1'b0;
        end
        ST_FETCH0: st <= ST_FETCH1;
        ST_FETCH1: begin
          w0     <= mem_q;
          plen   <= mem_q[CFG_LONG_BIT] ? ((wc > cap) ? cap : wc) : '0;
          rd_ptr <= QA_W'(1);
          hidx   <= '0;
          st     <= ST_HDR;
        end
        ST_HDR: begin
          tx_valid <= 1'b1;
          tx_first <= (hidx == 2'd0);
          case (hidx)
            2'd0:    tx_byte <= w0[15:8];
            2'd1:    tx_byte <= w0[23:16];
            default: tx_byte <= w0[31:24];
          endcase
          tx_last <= (hidx == 2'd2) && (plen == '0);
          hidx    <= hidx + 1'b1;
          if (hidx == 2'd2) begin
            pidx <= '0;
            st   <= (plen != '0) ? ST_PAY : ST_FIN;
          end
        end
        ST_PAY: begin
          tx_valid <= 1'b1;
          tx_byte  <= mem_q[{pidx[1:0], 3'b000} +: 8];
          tx_last  <= (pidx == plen_m1);
          // fetch the next word early to cover the read latency
          if (pidx[1:0] == 2'd2) rd_ptr <= rd_ptr + 1'b1;
          pidx <= pidx + 1'b1;
          if (pidx == plen_m1) st <= ST_FIN;
        end
        ST_FIN: begin
          if (w0[CFG_TA_BIT]) begin
            bta_req <= 1'b1;
            st      <= ST_WAIT;
          end else begin
            cmd_done <= 1'b1;
            busy     <= 1'b0;
            st       <= ST_IDLE;
          end
        end
        ST_WAIT: if (rd_ready) begin
          cmd_done <= 1'b1;
          busy     <= 1'b0;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_TX_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy) else $error("byte outside busy"); // R9
  AST_BTA_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bta_req |=> !bta_req) else $error("turnaround pulse too long"); // R11
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_done) |-> !busy) else $error("done while busy"); // R10
  AST_FIRST_IS_VALID: assert property (@(posedge clk) disable iff (rst)
    tx_first |-> tx_valid) else $error("first without valid"); // R12
  AST_LAST_ENDS_STREAM: assert property (@(posedge clk) disable iff (rst)
    tx_last |=> !tx_valid) else $error("byte after last"); // R3
endmodule

// File: rtl/cmdq_launcher.sv
module cmdq_launcher
  import cmdq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int QA_W = $clog2(DEPTH),
  localparam int ADDR_W = QA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              rd_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              tx_first,
  output logic              tx_last,
  output logic              bta_req,
  output logic              busy,
  output logic              cmd_done
);
  logic              q_we, launch, done_clr;
  logic [QA_W-1:0]   q_waddr, rd_ptr;
  logic [QSZ_W-1:0]  qsize;
  logic [WORD_W-1:0] mem_q;

  cmdq_regs #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy_i(busy), .q_we(q_we), .q_waddr(q_waddr),
    .qsize_o(qsize), .launch_o(launch), .done_clr_o(done_clr)
  );

  cmdq_mem #(.DEPTH(DEPTH), .W(WORD_W)) u_mem (
    .clk(clk), .we(q_we), .waddr(q_waddr), .wdata(cfg_wdata),
    .raddr(rd_ptr), .rdata(mem_q)
  );

  cmdq_serializer #(.DEPTH(DEPTH)) u_ser (
    .clk(clk), .rst(rst), .launch(launch), .qsize(qsize),
    .done_clr(done_clr), .mem_q(mem_q), .rd_ready(rd_ready),
    .rd_ptr(rd_ptr), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_first(tx_first), .tx_last(tx_last), .bta_req(bta_req),
    .busy(busy), .cmd_done(cmd_done)
  );
endmodule

// File: tb/cmdq_launcher_test.sv
`timescale 1ns/1ps
module cmdq_launcher_test;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH) + 1;
  localparam logic [AW-1:0] A_START = AW'(0), A_MODE = AW'(1),
                            A_QSIZE = AW'(2), A_CLEAR = AW'(3);

  typedef struct packed { logic [31:0] w0; logic [5:0] qs; logic [7:0] nb; } vec_t;
  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{32'h22110500, 6'd1,  8'd3},   // short
    '{32'h00AB1500, 6'd3,  8'd3},   // short, larger queue size
    '{32'h00053902, 6'd3,  8'd8},   // long, 5 bytes
    '{32'h00072902, 6'd2,  8'd7},   // long, clipped to 4
    '{32'h000C3902, 6'd4,  8'd15},  // long, 12 bytes
    '{32'h00003902, 6'd1,  8'd3},   // long, empty payload
    '{32'h00643902, 6'd63, 8'd63}   // long, size above depth
  };

  logic clk = 0, rst = 1, cfg_we = 0, rd_ready = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic tx_valid, tx_first, tx_last, bta_req, busy, cmd_done;
  logic [7:0] tx_byte;

  int nchk = 0, nfail = 0;
  logic [31:0] wq [DEPTH];
  logic [7:0] got [128];
  logic lastf [128];

  always #5 clk = ~clk;

  cmdq_launcher #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_ready(rd_ready), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .tx_first(tx_first), .tx_last(tx_last),
    .bta_req(bta_req), .busy(busy), .cmd_done(cmd_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at falling edge, returns at the next falling edge (cycle 0)
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic collect(input int maxc, output int n, output int fcyc,
                         output int ecyc, output bit flags_ok, output bit busy1);
    n = 0; fcyc = -1; ecyc = -1; flags_ok = 1; busy1 = 0;
    for (int c = 0; c < maxc; c++) begin
      if (c == 1) busy1 = busy && !cmd_done;
      if (tx_valid) begin
        if (n == 0) fcyc = c;
        if (tx_first != (n == 0)) flags_ok = 0;
        if (n < 128) begin got[n] = tx_byte; lastf[n] = tx_last; end
        n++;
      end else if (n != 0 && !cmd_done && !bta_req && busy) flags_ok = 0;
      if (c >= 1 && (cmd_done || bta_req)) begin ecyc = c; break; end
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int j, input logic [31:0] w0);
    if (j == 0) return w0[15:8];
    if (j == 1) return w0[23:16];
    if (j == 2) return w0[31:24];
    return wq[1 + (j-3)/4][8*((j-3)%4) +: 8];
  endfunction

  task automatic load(input logic [31:0] w0, input int v, input logic [5:0] qs);
    wq[0] = w0;
    for (int i = 1; i < DEPTH; i++)
      for (int b = 0; b < 4; b++) wq[i][8*b +: 8] = 8'((v*37 + i*4 + b) & 255);
    for (int i = 0; i < DEPTH; i++) wr(AW'(DEPTH + i), wq[i]);
    wr(A_QSIZE, {26'd0, qs});
    wr(A_START, 0);
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int n, fc, ec; bit fok, b1, lok;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !cmd_done && !tx_valid && !tx_first && !tx_last && !bta_req,
        "R1 reset", {busy, cmd_done, tx_valid, bta_req}, 0);

    // table walk: R2 R3 R4 R5 R9 R10 R12
    for (int v = 0; v < NV; v++) begin
      load(VEC[v].w0, v, VEC[v].qs);
      wr(A_START, 1);
      collect(200, n, fc, ec, fok, b1);
      chk(b1, "R9 busy in cycle 1", b1, 1);
      chk(fc == 4, "R9 first byte cycle", fc, 4);
      chk(n == int'(VEC[v].nb), "R3/R4/R5 byte count", n, VEC[v].nb);
      for (int j = 0; j < n && j < 128; j++)
        chk(got[j] == exp_byte(j, VEC[v].w0), "R2/R4 byte value", got[j], exp_byte(j, VEC[v].w0));
      lok = 1;
      for (int j = 0; j < n && j < 128; j++) if (lastf[j] != (j == n-1)) lok = 0;
      chk(lok, "R3 last flag", lok, 1);
      chk(fok, "R12 first flag and contiguity", fok, 1);
      chk(ec == 4 + int'(VEC[v].nb), "R10 done cycle", ec, 4 + VEC[v].nb);
      chk(cmd_done && !busy, "R10 done with busy low", {cmd_done, busy}, 2);
    end

    // R10 clear
    wr(A_CLEAR, 0);
    chk(!cmd_done, "R10 clear", cmd_done, 0);

    // R8 mode not command
    load(32'h22110500, 0, 6'd1);
    wr(A_MODE, 1);
    wr(A_START, 1);
    collect(12, n, fc, ec, fok, b1);
    chk(n == 0 && !busy, "R8 mode reject", n, 0);
    wr(A_MODE, 0);
    // R6 start already 1: no launch
    wr(A_START, 1);
    collect(12, n, fc, ec, fok, b1);
    chk(n == 0 && !busy, "R6 no edge no launch", n, 0);
    wr(A_START, 0);
    wr(A_START, 1);
    collect(40, n, fc, ec, fok, b1);
    chk(n == 3, "R6 rising edge launches", n, 3);

    // R8 empty queue
    wr(A_QSIZE, 0);
    wr(A_START, 0);
    wr(A_START, 1);
    collect(12, n, fc, ec, fok, b1);
    chk(n == 0 && !busy, "R8 zero size reject", n, 0);

    // R7 start write while busy is ignored
    load(32'h00643902, 6, 6'd63);
    wr(A_START, 1);
    repeat (6) @(negedge clk);
    chk(busy, "R7 busy during packet", busy, 1);
    wr(A_START, 0);            // ignored: start stays 1
    while (busy) @(negedge clk);
    wr(A_START, 1);            // no edge seen
    collect(12, n, fc, ec, fok, b1);
    chk(n == 0 && !busy, "R7 ignored write kept start high", n, 0);

    // R11 turnaround
    load(32'h000A0604, 7, 6'd1);
    wr(A_START, 1);
    collect(40, n, fc, ec, fok, b1);
    chk(n == 3, "R11 byte count", n, 3);
    chk(ec == 7 && bta_req, "R11 turnaround cycle", ec, 7);
    chk(busy && !cmd_done, "R11 done held", {busy, cmd_done}, 2);
    @(negedge clk);
    chk(!bta_req, "R11 pulse width", bta_req, 0);
    repeat (4) @(negedge clk);
    chk(busy && !cmd_done, "R11 waiting for read data", {busy, cmd_done}, 2);
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
    chk(cmd_done && !busy, "R11 done after read ready", {cmd_done, busy}, 2);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule